// File: doc/BRIEF.md
# Accelerometer Init and Sampling Sequencer

This block sits in front of a register access master and issues all the register accesses needed to bring up a three-axis accelerometer and then sample it without stopping. A serial-bus master carries each request to the sensor as one transaction, with chip select released between them. After reset the block reads the identity register and compares it with the expected byte. If the byte is wrong it stops and raises an error flag. Otherwise it programs the range and power configuration and sets a flag that bring-up is done.

From then on it runs a loop. Each pass reads six data bytes, one register per transaction, with the low byte of each axis read before its high byte. It assembles X, Y and Z as signed 16-bit values and presents all three together with a one-cycle valid strobe. A count on an input sets the idle interval that each pass waits before the next one starts.

The request side is a valid/ready handshake that carries a 6-bit register number, a write flag and the write data. The master is responsible for the read/write flag bit on the wire. For every accepted request, reads and writes alike, the master returns exactly one response pulse, which carries the read data.

Top module: `accel_seq`

## Requirements
- R1: While reset is held, the outputs `x`, `y`, `z`, `sample_valid`, `init_done` and `error` are zero. The first request after reset is a read (`req_write`=0) of register 0x00.
- R2: If the response to the identity read is not 0xE5, `error` goes to 1 and stays there until reset. No further request is issued, and `init_done` stays 0.
- R3: If the identity byte is 0xE5, the next request writes data 0x0F to register 0x31. The request after that writes data 0x08 to register 0x2D.
- R4: `init_done` is 0 until the response to the write of register 0x2D has been accepted. It is 1 from the cycle after that response and stays at 1 until reset.
- R5: After bring-up, reads repeat in the fixed order 0x32, 0x33, 0x34, 0x35, 0x36, 0x37, for as long as the block runs.
- R6: `x` = {byte of 0x33, byte of 0x32}, `y` = {byte of 0x35, byte of 0x34} and `z` = {byte of 0x37, byte of 0x36}, each read as a signed 16-bit value.
- R7: `sample_valid` is high for exactly one cycle, in the cycle after the response to the 0x37 read. The three axis outputs change only in that cycle, and all three change together.
- R8: At most one request is outstanding. A request stays asserted with stable fields until `req_ready` is high, and no new request appears until its response has arrived.
- R9: The next read of 0x32 is requested exactly `idle_cycles` cycles after the cycle in which `sample_valid` is high. With `idle_cycles`=0 it is requested in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_cycles | input | IDLE_W | Idle cycles between sample sets |
| req_valid | output | 1 | Request to register access master |
| req_write | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | 6 | Register number |
| req_wdata | output | 8 | Write data |
| req_ready | input | 1 | Master accepts the request |
| rsp_valid | input | 1 | One-cycle response pulse, one per accepted request |
| rsp_data | input | 8 | Read data carried with the response |
| x | output | 16 | X-axis sample, signed |
| y | output | 16 | Y-axis sample, signed |
| z | output | 16 | Z-axis sample, signed |
| sample_valid | output | 1 | One-cycle strobe when new samples are presented |
| init_done | output | 1 | Bring-up complete |
| error | output | 1 | Identity mismatch, sequence halted |

## Verification
The bench models the master with `req_ready` toggling in a repeating pattern and a response latency that changes from request to request, so a design that ignores the handshake or the response timing fails. One run uses a wrong identity byte and checks that the sequence halts after a single request. Two runs use the correct identity with idle counts of zero and five. These runs check the bring-up writes, the data read order and the idle gap. Each sample set uses a new axis pattern. Some sets use the boundary words 0x8000, 0x7FFF, 0xFFFF, 0x0000, 0x00FF and 0xFF00, and the rest use arithmetic values, so swapped bytes, swapped axes and stale bytes each give a mismatch.

// File: rtl/accel_seq.sv
module accel_seq #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDLE_W-1:0] idle_cycles,
  output logic              req_valid,
  output logic              req_write,
  output logic [5:0]        req_addr,
  output logic [7:0]        req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic [15:0]       x,
  output logic [15:0]       y,
  output logic [15:0]       z,
  output logic              sample_valid,
  output logic              init_done,
  output logic              error
);
  localparam logic [1:0] S_ISSUE = 2'd0, S_WAIT = 2'd1, S_GAP = 2'd2, S_HALT = 2'd3;
  localparam logic [3:0] STEP_FIRST = 4'd3, STEP_LAST = 4'd8;
  localparam logic [7:0] ID_BYTE = 8'hE5;

  logic [1:0]        st;
  logic [3:0]        step;
  logic [3:0]        bidx;
  logic [IDLE_W-1:0] gap_cnt;
  logic [7:0]        hold [0:4];

  assign req_valid = (st == S_ISSUE);
  assign bidx      = step - STEP_FIRST;

  always_comb begin
    req_write = 1'b0;
    req_wdata = 8'h00;
    req_addr  = 6'h2F + {2'b00, step};
    case (step)
      4'd0: req_addr = 6'h00;
      4'd1: begin req_addr = 6'h31; req_write = 1'b1; req_wdata = 8'h0F; end
      4'd2: begin req_addr = 6'h2D; req_write = 1'b1; req_wdata = 8'h08; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_ISSUE;
      step         <= 4'd0;
      gap_cnt      <= '0;
      x            <= '0;
      y            <= '0;
      z            <= '0;
      sample_valid <= 1'b0;
      init_done    <= 1'b0;
      error        <= 1'b0;
      for (int i = 0; i < 5; i++) hold[i] <= 8'h00;
    end else begin
      sample_valid <= 1'b0;
      case (st)
        S_ISSUE: if (req_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          st <= S_ISSUE;
          case (step)
            4'd0: if (rsp_data == ID_BYTE) step <= 4'd1;
                  else begin error <= 1'b1; st <= S_HALT; end
            4'd1: step <= 4'd2;
            4'd2: begin step <= STEP_FIRST; init_done <= 1'b1; end
            STEP_LAST: begin
              x <= {hold[1], hold[0]};
              y <= {hold[3], hold[2]};
              z <= {rsp_data, hold[4]};
              sample_valid <= 1'b1;
              step <= STEP_FIRST;
              gap_cnt <= '0;
              if (idle_cycles != '0) st <= S_GAP;
            end
            default: begin
              hold[bidx[2:0]] <= rsp_data;
              step <= step + 4'd1;
            end
          endcase
        end
        S_GAP: if (gap_cnt + 1'b1 >= idle_cycles) st <= S_ISSUE;
               else gap_cnt <= gap_cnt + 1'b1;
        default: ;
      endcase
    end
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable({req_write, req_addr, req_wdata}));
  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);
  p_init_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_error_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && !req_valid && !init_done);
  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  p_outputs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> sample_valid || $stable({x, y, z}));
  p_data_after_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> init_done);
endmodule

// File: tb/accel_seq_test.sv
`timescale 1ns/1ps
module accel_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] idle_cycles = 16'd0;
  logic        req_valid, req_write;
  logic [5:0]  req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'h00;
  logic [15:0] x, y, z;
  logic        sample_valid, init_done, error;

  accel_seq #(.IDLE_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .idle_cycles(idle_cycles),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .x(x), .y(y), .z(z),
    .sample_valid(sample_valid), .init_done(init_done), .error(error)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int n_txn = 0, set_no = 0, tick = 0, lat = 0, gap_m = 0;
  bit pend = 0, meas = 0, finished = 0;
  logic [7:0] id_val = 8'hE5, resp = 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int k, input int a);
    case (k % 4)
      0: pat = (a == 0) ? 16'h8000 : (a == 1) ? 16'h7FFF : 16'hFFFF;
      1: pat = (a == 0) ? 16'h0000 : (a == 1) ? 16'h00FF : 16'hFF00;
      default: pat = 16'(k * 16'h2F3B + a * 16'h1D07 + 16'h0101);
    endcase
  endfunction

  function automatic logic [7:0] rd_val(input logic [5:0] a);
    int off;
    logic [15:0] w;
    if (a == 6'h00) return id_val;
    off = int'(a) - 'h32;
    if (off < 0 || off > 5) return 8'h00;
    w = pat(set_no, off / 2);
    return (off % 2) ? w[15:8] : w[7:0];
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        req_ready = 0; rsp_valid = 0; pend = 0; meas = 0;
        n_txn = 0; set_no = 0;
      end else begin
        if (sample_valid) begin
          chk(x == pat(set_no, 0), "R6 x", x, pat(set_no, 0));
          chk(y == pat(set_no, 1), "R6 y", y, pat(set_no, 1));
          chk(z == pat(set_no, 2), "R6 z", z, pat(set_no, 2));
          chk(n_txn == 3 + 6 * (set_no + 1), "R7 strobe after sixth byte", n_txn, 3 + 6 * (set_no + 1));
          set_no++;
          gap_m = 0; meas = 1;
        end else if (meas) gap_m++;
        if (meas && req_valid) begin
          chk(gap_m == int'(idle_cycles), "R9 idle gap", gap_m, idle_cycles);
          meas = 0;
        end
        rsp_valid = 0;
        if (pend) begin
          if (lat == 0) begin rsp_valid = 1; rsp_data = resp; pend = 0; end
          else lat--;
        end
        req_ready = (tick % 3) != 1;
        tick++;
        if (req_valid && req_ready) begin
          chk(!pend && !rsp_valid, "R8 single outstanding", pend, 0);
          if (n_txn == 0)
            chk(req_addr == 0 && !req_write, "R1 first is id read", {req_write, req_addr}, 0);
          else if (n_txn == 1)
            chk(req_addr == 6'h31 && req_write && req_wdata == 8'h0F, "R3 range write",
                {req_write, req_addr, req_wdata}, {1'b1, 6'h31, 8'h0F});
          else if (n_txn == 2) begin
            chk(req_addr == 6'h2D && req_write && req_wdata == 8'h08, "R3 power write",
                {req_write, req_addr, req_wdata}, {1'b1, 6'h2D, 8'h08});
            chk(!init_done, "R4 init_done low before power write", init_done, 0);
          end else begin
            chk(req_addr == 6'h32 + 6'((n_txn - 3) % 6) && !req_write, "R5 read order",
                {req_write, req_addr}, 6'h32 + 6'((n_txn - 3) % 6));
            if (n_txn == 3) chk(init_done, "R4 init_done set", init_done, 1);
          end
          resp = rd_val(req_addr);
          pend = 1;
          lat = tick % 3;
          n_txn++;
        end
      end
    end
  end

  task automatic do_reset(input logic [7:0] idv, input logic [15:0] idl);
    rst_n = 0;
    id_val = idv;
    idle_cycles = idl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({x, y, z} == 48'h0, "R1 axes zero in reset", 0, 0);
    chk({sample_valid, init_done, error} == 3'b000, "R1 flags zero in reset",
        {sample_valid, init_done, error}, 0);
    rst_n = 1;
  endtask

  task automatic run_sets(input int n);
    int guard = 0;
    while (set_no < n && guard < 20000) begin @(negedge clk); guard++; end
    chk(set_no >= n, "R5 sample sets completed", set_no, n);
  endtask

  initial begin
    do_reset(8'hE4, 16'd2);
    repeat (200) @(negedge clk);
    chk(error, "R2 error on bad id", error, 1);
    chk(!init_done, "R2 init_done stays low", init_done, 0);
    chk(n_txn == 1, "R2 no further requests", n_txn, 1);
    chk(!req_valid, "R2 request idle", req_valid, 0);

    do_reset(8'hE5, 16'd0);
    run_sets(8);
    chk(!error && init_done, "R4 init_done held, no error", {error, init_done}, 1);

    do_reset(8'hE5, 16'd5);
    run_sets(6);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R5 actual=%0d expected=done", set_no);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule